// File: doc/BRIEF.md
# Translation Context Control and Fault Register Block

This block holds the per-context software-visible state of a multi-context I/O address translation unit. Each implemented context owns a 64-byte window with three live registers: a control word, a fault status word and a fault address word. It is reached through a plain 32-bit register port with combinational read data. The same register map also answers at a second copy 0x800 above the base. Walking page tables, storing TLB entries and translating addresses all belong to other blocks.

Software starts a TLB invalidation by setting the flush bit in a context's control word. It then polls that bit until it reads 0 again. A small per-context timer stands in for the invalidation engine and ends the flush a programmable number of cycles later.

Faults arrive on a dedicated input port tagged with a context number. The first fault after a clear is latched into that context's status and address words. A fault stays latched until software writes zero to the status word, which also zeroes the address word. A single interrupt line covers all contexts.

Top module: `xlat_ctx_regs`

## Requirements
- R1: After reset every register of every context reads 0 and `irq` is 0.
- R2: Context n occupies addresses n*0x40 to n*0x40+0x3F (address bits 8:6 select the context, bits 10:9 must be 0). Offset 0x00 is control, 0x20 is fault status and 0x30 is fault address. Any other offset reads 0 and ignores writes.
- R3: In the control word, bits 0 (translate enable), 2 (interrupt enable), 3 (table remap enable), 16 (access-flag software handling) and 17 (remap enable) read back as last written. Every other bit except the flush bit reads 0. Writing 0 clears all the stored bits, which disables the context.
- R4: Writing 1 to control bit 1 (flush) makes that bit read 1 for exactly L cycles, where L is `flush_lat` sampled on the write edge and a value of 0 counts as 1. The bit then reads 0 without any further write.
- R5: A flush write made while that context's flush is still pending is absorbed: the pending flush ends at its original time and no new flush is started.
- R6: A fault (`fault_valid`, implemented `fault_ctx`, nonzero `fault_flags`) on a context with no error flag latched is stored from the next cycle on. The status word gets translation fault in bit 0, page fault in bit 1, walk abort in bit 2, multiple hit in bit 4 (`fault_flags` bits 0, 1, 2 and 3 in that order), the error code in bits 10:8 and the lookup level in bits 13:12. The fault address word gets `fault_va`.
- R7: While any of the four error flags of a context is set, further faults on that context change neither of its fault registers.
- R8: Writing exactly 0 to a status word clears it and its fault address word, and this clear wins over a fault arriving in the same cycle. Nonzero status writes and all writes to the fault address word change nothing.
- R9: `irq` is 1 exactly when some context has control bit 2 set and at least one of its four error flags set.
- R10: Every register access also works with address bit 11 set, reaching the same register.
- R11: Contexts numbered N_CTX and above read 0 and ignore both writes and faults. N_CTX must lie between 1 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| flush_lat | input | LAT_W | Invalidation duration in cycles, sampled when a flush starts |
| fault_valid | input | 1 | A fault is reported this cycle |
| fault_ctx | input | 3 | Context the fault belongs to |
| fault_flags | input | 4 | {multiple hit, walk abort, page fault, translation fault} |
| fault_code | input | 3 | Error code of the fault |
| fault_level | input | 2 | Lookup level at which the fault arose |
| fault_va | input | 32 | Input address that faulted |
| irq | output | 1 | Shared fault interrupt |

## Verification
Directed sequences come first. Control writes of all-ones and all-zeros show which bits are stored. Flushes run at latencies 0, 1, 5 and 6, with and without a second flush write landing mid-flight, which tells a correct countdown apart from one that restarts or ends one cycle early or late. The fault tests use a first fault, a second fault, a nonzero status write, and a clear that coincides with a fault; together these separate first-fault capture, hold, the write-zero clear and the clear's priority. Accesses at the alias copy, at unused offsets, to unimplemented contexts and outside the window show the decode. A long pseudo-random mix of all of these is then compared cycle by cycle against the behavioural model.

// File: rtl/xctx_pkg.sv
package xctx_pkg;

   localparam int MAX_CTX  = 8;
   localparam int ADDR_W   = 12;
   localparam int CTX_IW   = 3;
   localparam int OFS_W    = 6;

   localparam logic [OFS_W-1:0] OFS_CTRL  = 6'h00;
   localparam logic [OFS_W-1:0] OFS_STAT  = 6'h20;
   localparam logic [OFS_W-1:0] OFS_FADDR = 6'h30;

   localparam logic [31:0] CTRL_KEEP_MASK = 32'h0003_000D;
   localparam int          CTRL_FLUSH_B   = 1;
   localparam int          CTRL_IRQEN_B   = 2;

   typedef struct packed {
      logic [1:0] level;
      logic [2:0] code;
      logic [3:0] flags;   // {multi-hit, walk abort, page, translation}
   } fault_rec_t;

   function automatic logic [31:0] stat_word(fault_rec_t r);
      return {18'd0, r.level, 1'b0, r.code, 3'd0, r.flags[3], 1'b0, r.flags[2:0]};
   endfunction

endpackage

// File: rtl/xctx_flush_stub.sv
module xctx_flush_stub #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat,
   output logic             busy
);
   logic [LAT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAT_W'(1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt - LAT_W'(1);
         end
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= (lat == '0) ? LAT_W'(1) : lat;
      end
   end

   AST_FLUSH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt != '0);                                                  // R4
   AST_FLUSH_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt > LAT_W'(1)) |=> (busy && cnt == $past(cnt) - LAT_W'(1))); // R5

endmodule

// File: rtl/xctx_slot.sv
module xctx_slot
   import xctx_pkg::*;
#(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_stat,
   input  logic [31:0]      wdata,
   input  logic [LAT_W-1:0] lat,
   input  logic             flt_hit,
   input  fault_rec_t       flt_rec,
   input  logic [31:0]      flt_va,
   output logic [31:0]      ctrl_rd,
   output logic [31:0]      stat_rd,
   output logic [31:0]      faddr_rd,
   output logic             irq_req
);
   logic [31:0] ctrl_r;
   fault_rec_t  rec_q;
   logic [31:0] va_q;
   logic        flush_busy;
   logic        clear;
   logic        armed;

   assign clear = wr_stat && (wdata == 32'd0);
   assign armed = (rec_q.flags == 4'd0);

   xctx_flush_stub #(.LAT_W(LAT_W)) u_flush (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_ctrl && wdata[CTRL_FLUSH_B]),
      .lat   (lat),
      .busy  (flush_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_r <= '0;
      end else if (wr_ctrl) begin
         ctrl_r <= wdata & CTRL_KEEP_MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_q <= '0;
         va_q  <= '0;
      end else if (clear) begin
         rec_q <= '0;
         va_q  <= '0;
      end else if (flt_hit && armed && (flt_rec.flags != 4'd0)) begin
         rec_q <= flt_rec;
         va_q  <= flt_va;
      end
   end

   always_comb begin
      ctrl_rd               = ctrl_r;
      ctrl_rd[CTRL_FLUSH_B] = flush_busy;
   end
   assign stat_rd  = stat_word(rec_q);
   assign faddr_rd = va_q;
   assign irq_req  = ctrl_r[CTRL_IRQEN_B] && !armed;

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (stat_rd == 32'd0 && faddr_rd == 32'd0));                   // R8
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !clear) |=> ($stable(stat_rd) && $stable(faddr_rd)));      // R7
   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_hit && flt_rec.flags != 4'd0 && armed && !clear) |=> faddr_rd == $past(flt_va)); // R6

endmodule

// File: rtl/xlat_ctx_regs.sv
module xlat_ctx_regs
   import xctx_pkg::*;
#(
   parameter int N_CTX = 8,
   parameter int LAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [11:0]       addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [LAT_W-1:0]  flush_lat,
   input  logic              fault_valid,
   input  logic [2:0]        fault_ctx,
   input  logic [3:0]        fault_flags,
   input  logic [2:0]        fault_code,
   input  logic [1:0]        fault_level,
   input  logic [31:0]       fault_va,
   output logic              irq
);
   localparam int WIN_LO = OFS_W + CTX_IW;

   if (N_CTX < 1 || N_CTX > MAX_CTX) begin : g_bad_ctx
      $error("xlat_ctx_regs: N_CTX must be 1..8");
   end
   if (LAT_W < 1) begin : g_bad_lat
      $error("xlat_ctx_regs: LAT_W must be at least 1");
   end

   logic              unused_alias;
   logic              win_ok;
   logic [CTX_IW-1:0] ctx_idx;
   logic [OFS_W-1:0]  ofs;
   fault_rec_t        rec_in;

   logic [31:0]      ctrl_rd  [N_CTX];
   logic [31:0]      stat_rd  [N_CTX];
   logic [31:0]      faddr_rd [N_CTX];
   logic [N_CTX-1:0] irq_vec;

   assign unused_alias = addr[ADDR_W-1];           // alias bit: both copies decode alike
   assign win_ok       = (addr[ADDR_W-2:WIN_LO] == '0);
   assign ctx_idx      = addr[WIN_LO-1:OFS_W];
   assign ofs          = addr[OFS_W-1:0];
   assign rec_in       = '{level: fault_level, code: fault_code, flags: fault_flags};

   for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      logic sel;
      assign sel = win_ok && (ctx_idx == CTX_IW'(c));

      xctx_slot #(.LAT_W(LAT_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_ctrl  (wr_en && sel && ofs == OFS_CTRL),
         .wr_stat  (wr_en && sel && ofs == OFS_STAT),
         .wdata    (wdata),
         .lat      (flush_lat),
         .flt_hit  (fault_valid && fault_ctx == CTX_IW'(c)),
         .flt_rec  (rec_in),
         .flt_va   (fault_va),
         .ctrl_rd  (ctrl_rd[c]),
         .stat_rd  (stat_rd[c]),
         .faddr_rd (faddr_rd[c]),
         .irq_req  (irq_vec[c])
      );
   end

   always_comb begin
      rdata = 32'd0;
      for (int c = 0; c < N_CTX; c++) begin
         if (win_ok && ctx_idx == CTX_IW'(c)) begin
            case (ofs)
               OFS_CTRL:  rdata = ctrl_rd[c];
               OFS_STAT:  rdata = stat_rd[c];
               OFS_FADDR: rdata = faddr_rd[c];
               default:   rdata = 32'd0;
            endcase
         end
      end
   end

   assign irq = |irq_vec;

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(fault_valid) || $past(wr_en)));                 // R9

endmodule

// File: tb/tb_xlat_ctx_regs.sv
`timescale 1ns/1ps
module tb_xlat_ctx_regs;
   localparam int NC = 4;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [LW-1:0] flush_lat = '0;
   logic          fault_valid = 1'b0;
   logic [2:0]    fault_ctx = '0;
   logic [3:0]    fault_flags = '0;
   logic [2:0]    fault_code = '0;
   logic [1:0]    fault_level = '0;
   logic [31:0]   fault_va = '0;
   logic          irq;

   always #10 clk = ~clk;   // 50 MHz

   xlat_ctx_regs #(.N_CTX(NC), .LAT_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .flush_lat(flush_lat), .fault_valid(fault_valid),
      .fault_ctx(fault_ctx), .fault_flags(fault_flags), .fault_code(fault_code),
      .fault_level(fault_level), .fault_va(fault_va), .irq(irq)
   );

   // behavioural reference state
   logic [31:0] m_ctrl [8];
   logic [31:0] m_stat [8];
   logic [31:0] m_fva  [8];
   bit          m_pend [8];
   int          m_rem  [8];

   int    n_vec = 0;
   int    n_bad = 0;
   int    n_cyc = 0;
   string tag = "R1";

   function automatic bit dec(input logic [11:0] a, output int c, output int o);
      c = int'(a[8:6]);
      o = int'(a[5:0]);
      return (a[10:9] == 2'b00) && (c < NC);
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      int c, o;
      if (!dec(a, c, o)) return 32'd0;
      if (o == 'h00) return m_ctrl[c] | (m_pend[c] ? 32'h2 : 32'h0);
      if (o == 'h20) return m_stat[c];
      if (o == 'h30) return m_fva[c];
      return 32'd0;
   endfunction

   function automatic bit m_irq();
      for (int c = 0; c < 8; c++)
         if (m_ctrl[c][2] && (m_stat[c] & 32'h17) != 0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic m_reset();
      for (int c = 0; c < 8; c++) begin
         m_ctrl[c] = 0; m_stat[c] = 0; m_fva[c] = 0; m_pend[c] = 0; m_rem[c] = 0;
      end
   endtask

   task automatic m_update();
      int  wc, wo;
      bit  hit;
      hit = wr_en && dec(addr, wc, wo);
      for (int c = 0; c < NC; c++) begin
         bit wctrl, clr;
         wctrl = hit && wc == c && wo == 'h00;
         clr   = hit && wc == c && wo == 'h20 && wdata == 0;
         if (m_pend[c]) begin
            if (m_rem[c] == 1) m_pend[c] = 0;
            else m_rem[c]--;
         end else if (wctrl && wdata[1]) begin
            m_pend[c] = 1;
            m_rem[c]  = (flush_lat == 0) ? 1 : int'(flush_lat);
         end
         if (wctrl) m_ctrl[c] = wdata & 32'h0003_000D;
         if (clr) begin
            m_stat[c] = 0; m_fva[c] = 0;
         end else if (fault_valid && int'(fault_ctx) == c && fault_flags != 0
                      && (m_stat[c] & 32'h17) == 0) begin
            m_stat[c] = (32'(fault_level) << 12) | (32'(fault_code) << 8)
                      | (32'(fault_flags[3]) << 4) | 32'(fault_flags[2:0]);
            m_fva[c]  = fault_va;
         end
      end
   endtask

   task automatic compare();
      logic [31:0] exp_d;
      bit exp_i;
      exp_d = m_read(addr);
      exp_i = m_irq();
      n_vec++;
      if (rdata !== exp_d) begin
         n_bad++;
         $display("FAIL %s: addr=%h rdata actual=%h expected=%h", tag, addr, rdata, exp_d);
      end
      n_vec++;
      if (irq !== exp_i) begin
         n_bad++;
         $display("FAIL R9 (%s): irq actual=%b expected=%b", tag, irq, exp_i);
      end
   endtask

   // one clock: inputs set before, model follows the edge, compare at negedge
   task automatic tick();
      @(posedge clk);
      m_update();
      @(negedge clk);
      compare();
      wr_en = 1'b0;
      fault_valid = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1; tick();
   endtask

   task automatic rd(input logic [11:0] a);
      addr = a; tick();
   endtask

   task automatic flt(input int c, input logic [3:0] f, input logic [2:0] code,
                      input logic [1:0] lvl, input logic [31:0] va);
      fault_valid = 1'b1; fault_ctx = 3'(c); fault_flags = f;
      fault_code = code; fault_level = lvl; fault_va = va;
      tick();
   endtask

   function automatic logic [11:0] ra(input int c, input int o);
      return 12'(c * 'h40 + o);
   endfunction

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 100000) begin
         n_bad++;
         $display("FAIL R1 watchdog: cycles actual=%0d expected<=%0d", n_cyc, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      tag = "R1";
      for (int c = 0; c < NC; c++) begin
         rd(ra(c, 'h00)); rd(ra(c, 'h20)); rd(ra(c, 'h30));
      end

      tag = "R3";
      wr(ra(2, 'h00), 32'hFFFF_FFFD); rd(ra(2, 'h00));
      wr(ra(2, 'h00), 32'h0); rd(ra(2, 'h00));

      tag = "R2";
      wr(ra(1, 'h04), 32'hFFFF_FFFF); rd(ra(1, 'h04)); rd(ra(1, 'h00));
      wr(12'h210, 32'h5); rd(12'h210); rd(12'h010);

      tag = "R4";
      flush_lat = 8'd5;
      wr(ra(1, 'h00), 32'h3);
      repeat (7) rd(ra(1, 'h00));
      flush_lat = 8'd0;
      wr(ra(1, 'h00), 32'h2);
      repeat (3) rd(ra(1, 'h00));
      flush_lat = 8'd1;
      wr(ra(3, 'h00), 32'h2);
      repeat (2) rd(ra(3, 'h00));

      tag = "R5";
      flush_lat = 8'd6;
      wr(ra(0, 'h00), 32'h2);
      rd(ra(0, 'h00));
      flush_lat = 8'd9;
      wr(ra(0, 'h00), 32'h2);
      repeat (8) rd(ra(0, 'h00));

      tag = "R6";
      flt(0, 4'b0001, 3'd4, 2'd2, 32'hDEAD_BEEF);
      rd(ra(0, 'h20)); rd(ra(0, 'h30));
      tag = "R9";
      wr(ra(0, 'h00), 32'h5); rd(ra(0, 'h20));

      tag = "R7";
      flt(0, 4'b0010, 3'd5, 2'd1, 32'h1234_5678);
      rd(ra(0, 'h20)); rd(ra(0, 'h30));

      tag = "R8";
      wr(ra(0, 'h20), 32'h1); rd(ra(0, 'h20));
      wr(ra(0, 'h30), 32'h0); rd(ra(0, 'h30));
      rd(ra(0, 'h30));
      wr(ra(0, 'h20), 32'h0); rd(ra(0, 'h30)); rd(ra(0, 'h20));
      // clear and fault in the same cycle
      fault_valid = 1'b1; fault_ctx = 3'd0; fault_flags = 4'b0100;
      fault_code = 3'd1; fault_level = 2'd3; fault_va = 32'hCAFE_0000;
      wr(ra(0, 'h20), 32'h0);
      rd(ra(0, 'h20)); rd(ra(0, 'h30));

      tag = "R6";
      flt(0, 4'b1000, 3'd1, 2'd3, 32'h0BAD_F00D);
      rd(ra(0, 'h20)); rd(ra(0, 'h30));
      flt(2, 4'b0000, 3'd7, 2'd1, 32'hFFFF_0000);
      rd(ra(2, 'h20));

      tag = "R10";
      wr(12'h800 | ra(2, 'h00), 32'h0003_0009); rd(ra(2, 'h00));
      flt(2, 4'b0100, 3'd5, 2'd0, 32'h00C0_FFEE);
      rd(12'h800 | ra(2, 'h30));
      wr(12'h800 | ra(2, 'h20), 32'h0); rd(ra(2, 'h20));

      tag = "R11";
      wr(ra(5, 'h00), 32'h0003_000F); rd(ra(5, 'h00));
      flt(6, 4'b0001, 3'd1, 2'd1, 32'h5555_AAAA);
      rd(ra(6, 'h20)); rd(ra(6, 'h30)); rd(12'h800 | ra(7, 'h00));

      tag = "R9";
      wr(ra(0, 'h20), 32'h0); rd(ra(0, 'h00));
      flt(1, 4'b0010, 3'd4, 2'd2, 32'h7000_0000); rd(ra(1, 'h20));
      wr(ra(1, 'h00), 32'h4); rd(ra(1, 'h00));
      wr(ra(1, 'h00), 32'h0); rd(ra(1, 'h00));

      tag = "R4";
      for (int i = 0; i < 1500; i++) begin
         int c, o, k;
         c = $urandom_range(0, 7);
         k = $urandom_range(0, 4);
         o = (k == 0) ? 'h00 : (k == 1) ? 'h20 : (k == 2) ? 'h30 : (k == 3) ? 'h04 : 'h3C;
         addr = ra(c, o) | ($urandom_range(0, 1) ? 12'h800 : 12'h0);
         wr_en = ($urandom_range(0, 3) == 0);
         wdata = $urandom_range(0, 2) == 0 ? 32'h0 : $urandom;
         flush_lat = LW'($urandom_range(0, 7));
         fault_valid = ($urandom_range(0, 3) == 0);
         fault_ctx = 3'($urandom_range(0, 7));
         fault_flags = 4'($urandom_range(0, 15));
         fault_code = 3'($urandom_range(0, 7));
         fault_level = 2'($urandom_range(0, 3));
         fault_va = $urandom;
         tick();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule